// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This peripheral holds four independent down-counters behind one synchronous register bus. Each channel has an immediate load register, a readable current count, a control register and a reload register. A write to the reload register takes effect only the next time the count expires, so software can retune a running period without disturbing the interval already under way. Each channel decrements once per prescaled tick. The prescaler divides the bus clock by 1, 16 or 256.

A channel runs in one of three modes. In free-running mode it wraps to all ones. In periodic mode it reloads from the reload register. In one-shot mode it halts at zero and clears its own enable. A channel counts across either a 16-bit or a 32-bit width. When a channel's count reaches zero, a per-channel status flag is set. A shared mask register gates these flags onto a single interrupt line. A write-one-to-clear register acknowledges them.

Top module: `quad_dcount_timer`

## Requirements
- R1: After reset, every readable register reads zero and `irq` is low.
- R2: An enabled channel decrements its current value by one on each prescaler tick. Writing the load register sets the count at once. It also restarts the prescaler, and so does a control write that turns the enable bit from 0 to 1.
- R3: Control bits 3:2 choose the tick period: 00 gives one bus clock, 01 gives 16 and 10 gives 256. Code 11 also gives 256.
- R4: Control bit 6 = 0 and bit 0 = 0 selects free-running mode. On the tick after the count reaches zero, the count becomes all ones of the selected width.
- R5: Control bit 6 = 1 selects periodic mode. On the tick after the count reaches zero, the count takes the reload register value (channel offset +0xC). Writing the reload register does not change the current count.
- R6: Control bit 0 = 1 selects one-shot mode, and it takes priority over bit 6. When the count reaches zero, the count stays at zero and hardware clears control bit 7 (enable).
- R7: Control bit 1 = 0 selects 16-bit counting. Only the low 16 bits count and wrap, and the current value reads back zero-extended.
- R8: Bit n of the raw status register (0x04) is set on the tick where channel n's count goes from 1 to 0. Bus writes to 0x04 and 0x08 are ignored.
- R9: Writing 1 to bit n of 0x0C clears raw bit n, and 0 bits leave their flags alone. If a zero event and a clear hit the same cycle, the flag ends up set.
- R10: The mask register at 0x00 reads back what was written. The masked status at 0x08 equals raw AND mask. `irq` is the OR of the masked bits.
- R11: Channel n's registers sit at 0x10 + 0x10·n: load +0x0, current +0x4, control +0x8, reload +0xC. Control bits 5:4 read as zero. Offset 0x0C and addresses above the last channel read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR of the masked status bits |

## Verification
Properties check the following on every clock:
- a single-step decrement on each tick;
- the wrap to all ones in free-running mode;
- the reload value taken in periodic mode;
- the halt and enable clear in one-shot mode;
- the rule that a zero event always sets its flag and that a clear only affects flags without a simultaneous event.

Only the bench's scenarios show the following:
- the true tick period for each prescaler code and the restart on a load;
- the address map and reserved-bit readback;
- 16-bit zero extension;
- how the mask routes flags to the interrupt line.

// File: rtl/qdt_pkg.sv
package qdt_pkg;
   localparam int BUS_W  = 32;
   localparam int CTRL_W = 8;

   typedef struct packed {
      logic       en;        // bit 7
      logic       periodic;  // bit 6
      logic [1:0] rsvd;      // bits 5:4, always zero
      logic [1:0] presc;     // bits 3:2
      logic       wide;      // bit 1
      logic       single;    // bit 0
   } ctrl_t;

   typedef enum logic [1:0] {
      SLOT_LOAD = 2'd0,
      SLOT_CUR  = 2'd1,
      SLOT_CTRL = 2'd2,
      SLOT_BGL  = 2'd3
   } slot_e;

   function automatic ctrl_t ctrl_from_bus(input logic [CTRL_W-1:0] d);
      ctrl_t c;
      c      = ctrl_t'(d);
      c.rsvd = 2'b00;
      return c;
   endfunction
endpackage

// File: rtl/qdt_prescaler.sv
module qdt_prescaler #(
   parameter int PRE_SHIFT = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       restart,
   input  logic [1:0] code,
   output logic       tick
);
   localparam int DIV_W = 2 * PRE_SHIFT;

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim;

   generate
      if (PRE_SHIFT < 1 || PRE_SHIFT > 12) begin : g_bad_shift
         $error("qdt_prescaler: PRE_SHIFT out of range");
      end
   endgenerate

   always_comb begin
      case (code)
         2'b00:   lim = '0;
         2'b01:   lim = DIV_W'((1 << PRE_SHIFT) - 1);
         default: lim = '1;
      endcase
   end

   assign tick = run && (cnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (run)     cnt_q <= tick ? '0 : cnt_q + 1'b1;
   end

   // R3
   tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !restart) |=> (cnt_q == '0));
endmodule

// File: rtl/qdt_channel.sv
module qdt_channel
   import qdt_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int NARROW_W  = 16,
   parameter int PRE_SHIFT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_load,
   input  logic             we_ctrl,
   input  logic             we_bgl,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] load_rd,
   output logic [BUS_W-1:0] cur_rd,
   output logic [BUS_W-1:0] ctrl_rd,
   output logic [BUS_W-1:0] bgl_rd,
   output logic             zero_evt
);
   localparam logic [CNT_W-1:0] NARROW_MASK = CNT_W'({NARROW_W{1'b1}});

   ctrl_t            ctrl_q, ctrl_new;
   logic [CNT_W-1:0] load_q, cur_q, bgl_q;
   logic [CNT_W-1:0] wmask, val, nxt;
   logic             tick, en_rise;

   generate
      if (CNT_W > BUS_W || NARROW_W < 1 || NARROW_W >= CNT_W) begin : g_bad_width
         $error("qdt_channel: width parameters inconsistent");
      end
   endgenerate

   assign ctrl_new = ctrl_from_bus(wdata[CTRL_W-1:0]);
   assign en_rise  = we_ctrl && ctrl_new.en && !ctrl_q.en;
   assign wmask    = ctrl_q.wide ? '1 : NARROW_MASK;
   assign val      = cur_q & wmask;

   qdt_prescaler #(.PRE_SHIFT(PRE_SHIFT)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q.en),
      .restart (we_load || en_rise),
      .code    (ctrl_q.presc),
      .tick    (tick)
   );

   assign zero_evt = tick && !we_load && (val == CNT_W'(1));

   always_comb begin
      nxt = cur_q;
      if (tick) begin
         if (val != '0)           nxt = (val - CNT_W'(1)) & wmask;
         else if (ctrl_q.single)  nxt = val;
         else if (ctrl_q.periodic) nxt = bgl_q & wmask;
         else                     nxt = wmask;
      end
      if (we_load) nxt = wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         load_q <= '0;
         cur_q  <= '0;
         bgl_q  <= '0;
      end else begin
         cur_q <= nxt;
         if (we_load) load_q <= wdata[CNT_W-1:0];
         if (we_bgl)  bgl_q  <= wdata[CNT_W-1:0];
         if (we_ctrl)                        ctrl_q    <= ctrl_new;
         else if (zero_evt && ctrl_q.single) ctrl_q.en <= 1'b0;
      end
   end

   assign load_rd = BUS_W'(load_q);
   assign cur_rd  = BUS_W'(val);
   assign ctrl_rd = BUS_W'(ctrl_q);
   assign bgl_rd  = BUS_W'(bgl_q);

   // R2
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !we_load && !we_ctrl && val != '0) |=> (cur_rd == BUS_W'($past(val) - CNT_W'(1))));
   // R4
   free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !we_load && !we_ctrl && val == '0 && !ctrl_q.single && !ctrl_q.periodic)
      |=> (cur_q == $past(wmask)));
   // R5
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !we_load && !we_ctrl && val == '0 && !ctrl_q.single && ctrl_q.periodic)
      |=> (cur_q == ($past(bgl_q) & $past(wmask))));
   // R6
   oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt && ctrl_q.single && !we_ctrl) |=> (!ctrl_q.en && cur_q == '0));
endmodule

// File: rtl/qdt_irq.sv
module qdt_irq #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] evt,
   input  logic              we_mask,
   input  logic              we_clr,
   input  logic [NUM_CH-1:0] wbits,
   output logic [NUM_CH-1:0] mask_q,
   output logic [NUM_CH-1:0] raw_q,
   output logic [NUM_CH-1:0] masked,
   output logic              irq
);
   logic [NUM_CH-1:0] clr_bits;

   assign clr_bits = we_clr ? wbits : '0;
   assign masked   = raw_q & mask_q;
   assign irq      = |masked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q  <= '0;
         mask_q <= '0;
      end else begin
         raw_q <= (raw_q & ~clr_bits) | evt;
         if (we_mask) mask_q <= wbits;
      end
   end

   // R8
   raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((raw_q & $past(evt)) == $past(evt)));
   // R9
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_clr |=> ((raw_q & $past(wbits & ~evt)) == '0));
   // R10
   quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw_q & mask_q) == '0) |-> !irq);
endmodule

// File: rtl/quad_dcount_timer.sv
module quad_dcount_timer
   import qdt_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int CNT_W     = 32,
   parameter int NARROW_W  = 16,
   parameter int PRE_SHIFT = 4,
   parameter int ADDR_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq
);
   localparam int PAGE_W = ADDR_W - 4;

   logic [PAGE_W-1:0] page;
   logic [1:0]        slot;
   logic [NUM_CH-1:0] evt, mask_q, raw_q, masked;
   logic [BUS_W-1:0]  ch_rd [NUM_CH][4];
   logic              shared_we;

   generate
      if (NUM_CH < 1 || NUM_CH > BUS_W || (NUM_CH + 1) > (1 << PAGE_W)) begin : g_bad_map
         $error("quad_dcount_timer: channel count does not fit the address map");
      end
   endgenerate

   assign page      = bus_addr[ADDR_W-1:4];
   assign slot      = bus_addr[3:2];
   assign shared_we = bus_we && (page == '0);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic sel;
      assign sel = bus_we && (page == PAGE_W'(g + 1));
      qdt_channel #(.CNT_W(CNT_W), .NARROW_W(NARROW_W), .PRE_SHIFT(PRE_SHIFT)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .we_load  (sel && slot == SLOT_LOAD),
         .we_ctrl  (sel && slot == SLOT_CTRL),
         .we_bgl   (sel && slot == SLOT_BGL),
         .wdata    (bus_wdata),
         .load_rd  (ch_rd[g][0]),
         .cur_rd   (ch_rd[g][1]),
         .ctrl_rd  (ch_rd[g][2]),
         .bgl_rd   (ch_rd[g][3]),
         .zero_evt (evt[g])
      );
   end

   qdt_irq #(.NUM_CH(NUM_CH)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .we_mask (shared_we && slot == 2'd0),
      .we_clr  (shared_we && slot == 2'd3),
      .wbits   (bus_wdata[NUM_CH-1:0]),
      .mask_q  (mask_q),
      .raw_q   (raw_q),
      .masked  (masked),
      .irq     (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (page == '0) begin
         case (slot)
            2'd0:    bus_rdata = BUS_W'(mask_q);
            2'd1:    bus_rdata = BUS_W'(raw_q);
            2'd2:    bus_rdata = BUS_W'(masked);
            default: bus_rdata = '0;
         endcase
      end
      for (int i = 0; i < NUM_CH; i++) begin
         if (page == PAGE_W'(i + 1)) bus_rdata = ch_rd[i][slot];
      end
   end
endmodule

// File: tb/test_quad_dcount_timer.sv
module test_quad_dcount_timer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   quad_dcount_timer i_quad_dcount_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
   );

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; we = 1'b1; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      addr = a; #1;
      n_chk++;
      if (rdata !== exp) begin
         n_fail++;
         $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
      end
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      #1; n_chk++;
      if (irq !== exp) begin
         n_fail++;
         $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      edges(3);
      rst_n = 1'b1;
      edges(1);
      // R1: reset state over the whole map
      for (int a = 0; a < 8'h50; a += 4) chk(8'(a), 32'h0, "R1 reset value");
      chk_irq(1'b0, "R1 reset irq");

      // R2 R3: decrement rate for every prescaler code on channel 0
      for (int c = 0; c < 4; c++) begin
         int d;
         int at;
         d  = (c == 0) ? 1 : (c == 1) ? 16 : 256;
         at = 0;
         wr(8'h18, 32'h0);
         wr(8'h10, 32'd1000);
         wr(8'h18, 32'h82 | 32'(c << 2));
         for (int j = 0; j < 5; j++) begin
            int off;
            off = (j == 0) ? 0 : (j == 1) ? d - 1 : (j == 2) ? d : (j == 3) ? 3*d - 1 : 3*d;
            edges(off - at);
            at = off;
            chk(8'h14, 32'(1000 - off / d), "R3 prescaled count");
         end
      end
      // R2: load write mid-run restarts the prescaler (code 01)
      wr(8'h18, 32'h86);
      edges(20);
      wr(8'h10, 32'd500);
      chk(8'h14, 32'd500, "R2 immediate load");
      edges(15);
      chk(8'h14, 32'd500, "R2 prescaler restarted");
      edges(1);
      chk(8'h14, 32'd499, "R2 first tick after load");
      wr(8'h18, 32'h0);

      // R4: free-running 32-bit wrap on channel 1
      wr(8'h0C, 32'hF);
      wr(8'h20, 32'd2);
      wr(8'h28, 32'h82);
      edges(2);
      chk(8'h24, 32'h0, "R4 reaches zero");
      chk(8'h04, 32'h2, "R8 raw set at zero");
      edges(1);
      chk(8'h24, 32'hFFFF_FFFF, "R4 wrap to max");
      edges(1);
      chk(8'h24, 32'hFFFF_FFFE, "R4 keeps counting");
      wr(8'h28, 32'h0);

      // R7: 16-bit width
      wr(8'h20, 32'h0005_0002);
      chk(8'h24, 32'h0000_0002, "R7 zero-extended read");
      wr(8'h28, 32'h80);
      edges(3);
      chk(8'h24, 32'h0000_FFFF, "R7 16-bit wrap");
      wr(8'h28, 32'h0);

      // R5: periodic reload on channel 2
      wr(8'h0C, 32'hF);
      wr(8'h30, 32'd3);
      wr(8'h3C, 32'd5);
      chk(8'h34, 32'd3, "R5 reload write leaves count");
      wr(8'h38, 32'hC2);
      for (int m = 0; m <= 20; m++) begin
         int e;
         e = (m <= 3) ? 3 - m : 5 - ((m - 4) % 6);
         chk(8'h34, 32'(e), "R5 periodic sequence");
         edges(1);
      end
      chk(8'h04, 32'h4, "R8 periodic raw");
      wr(8'h38, 32'h0);

      // R6: one-shot on channel 3
      wr(8'h0C, 32'hF);
      wr(8'h40, 32'd4);
      wr(8'h48, 32'h83);
      edges(4);
      chk(8'h44, 32'h0, "R6 one-shot zero");
      edges(6);
      chk(8'h44, 32'h0, "R6 one-shot holds");
      chk(8'h48, 32'h03, "R6 enable cleared");
      chk(8'h04, 32'h8, "R8 one-shot raw");
      // R6: one-shot wins over periodic
      wr(8'h0C, 32'hF);
      wr(8'h4C, 32'd7);
      wr(8'h40, 32'd2);
      wr(8'h48, 32'hC3);
      edges(6);
      chk(8'h44, 32'h0, "R6 priority over periodic");
      chk(8'h48, 32'h43, "R6 enable cleared periodic");

      // R8 R10 R9: status, mask and interrupt line
      wr(8'h0C, 32'hF);
      chk(8'h04, 32'h0, "R9 clear all");
      chk_irq(1'b0, "R10 idle");
      wr(8'h20, 32'd1);
      wr(8'h28, 32'h83);
      edges(2);
      chk(8'h04, 32'h2, "R8 event flag");
      chk(8'h08, 32'h0, "R10 masked off");
      chk_irq(1'b0, "R10 masked line low");
      wr(8'h00, 32'h2);
      chk(8'h00, 32'h2, "R10 mask readback");
      chk(8'h08, 32'h2, "R10 masked status");
      chk_irq(1'b1, "R10 line high");
      wr(8'h04, 32'h0);
      wr(8'h08, 32'h0);
      chk(8'h04, 32'h2, "R8 status writes ignored");
      wr(8'h0C, 32'h1);
      chk(8'h04, 32'h2, "R9 other bit untouched");
      wr(8'h0C, 32'h2);
      chk(8'h04, 32'h0, "R9 flag cleared");
      chk_irq(1'b0, "R9 line dropped");
      // R9: event and clear in the same cycle
      wr(8'h30, 32'd2);
      wr(8'h38, 32'h83);
      wr(8'h0C, 32'h4);
      chk(8'h04, 32'h4, "R9 set wins over clear");

      // R11: reserved bits and unmapped space
      wr(8'h18, 32'h3F);
      chk(8'h18, 32'h0F, "R11 reserved ctrl bits");
      chk(8'h0C, 32'h0, "R11 clear reg reads zero");
      chk(8'h50, 32'h0, "R11 unmapped read");
      chk(8'h30, 32'd2, "R11 channel 2 load slot");
      chk(8'h3C, 32'd7 - 32'd7 + 32'd5, "R11 channel 2 reload slot");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule